// File: doc/BRIEF.md
# PCIe Configuration Image Load Sequencer

This block loads a core image into a programmable device over its PCIe link. It works through two channels. The first is a configuration-space register channel that reads and writes 32-bit words at offsets relative to the configuration capability. The second is a memory-write channel whose every beat lands on one fixed data location. Image words come in on a ready/valid stream, and the word count is given with the start pulse. A word count may come from a byte length that is not a multiple of four; the producer rounds it up to a whole final word before start.

A run begins with a start pulse. The block first checks that the link-configuration feature is enabled. If an earlier attempt left configuration mode on, it cleans that up. It then arms the device, streams the image and returns the device to user mode. Every mode change is followed by a flush of all-ones writes on the data channel. Every wait for a status bit polls at a fixed interval and gives up after a bounded number of cycles. Once arming has succeeded, the return to user mode always runs. The block ends in a done or error state that holds until the next start, and it reports the phase in which the first failure happened.

Top module: `cfgload_seq`

## Requirements
- R1: After reset the phase code is 0 (idle), done and error are low, and neither channel has a request pending.
- R2: If status bit 20 (offset 0x1C) reads 0 at start, the run ends in error with fail phase 1 (check). No configuration write and no data write is issued.
- R3: If mode-control bit 0 (offset 0x20) reads 1 at start, the full return sequence runs before arming, and its outcome does not affect the result. Its first write clears bit 1 of offset 0x2C. Phase code 2 is shown while this sequence runs.
- R4: Arming runs in this order. Set mode-control bit 1, then set bit 0. Set the clock-count field to 0x01 and flush. Set bit 0 of offset 0x2C. Wait for status bit 18 to read 1. Set the clock-count field to 0x01 again and flush. Set bit 1 of offset 0x2C.
- R5: Each flush is FLUSH_N (244) writes of 0xFFFFFFFF on the data channel, with backpressure honoured.
- R6: If status bit 18 does not rise while arming, the block clears mode-control bit 0 and then bit 1. The run ends in error with fail phase 3, and the return sequence does not run.
- R7: Streaming first sets the clock-count field to 0x08. It then forwards exactly the given number of image words, in order, to the data channel. A count of zero forwards nothing.
- R8: After streaming, status bit 19 is read. A value of 1 marks a failure with fail phase 4, and the return sequence still runs.
- R9: The return sequence runs in this order. Clear bit 1 of offset 0x2C, then bit 0. Set the clock-count field to 0x01 and flush. Wait for status bit 18 to read 0. Read latch bit 5 at offset 0x34. Clear mode-control bit 0, then bit 1.
- R10: If the latch bit is set, the block writes it back as 1 to clear it and then skips the waits on status bits 24 and 21. The run may still end in done.
- R11: Every wait polls the bit every POLL_CYC cycles and gives up after TIMEOUT_CYC cycles. If the latch bit was clear, the return sequence waits for status bit 24 and then bit 21 to read 1. A timeout during the return sequence ends the run in error with fail phase 5, unless an earlier phase already failed.
- R12: Every single-bit change is a read-modify-write of the whole word that keeps all other bits. A clock-count update replaces only bits 15:8 of mode control.
- R13: Phase codes are 0 idle, 1 check, 2 recover, 3 arm, 4 stream, 5 return, 6 done and 7 fail. Done and error are never high together, and both hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle, done or failed |
| img_dwords | input | LEN_W | Image length in 32-bit words, sampled with start |
| cfg_req | output | 1 | Configuration access request, held until acknowledged |
| cfg_we | output | 1 | 1 for a write, 0 for a read |
| cfg_addr | output | 8 | Capability-relative register offset |
| cfg_wdata | output | 32 | Write data |
| cfg_ack | input | 1 | One-cycle acknowledge of the current access |
| cfg_rdata | input | 32 | Read data, valid with cfg_ack |
| mem_valid | output | 1 | Data-channel write valid |
| mem_data | output | 32 | Data-channel write word |
| mem_ready | input | 1 | Data channel accepts the word |
| img_valid | input | 1 | Image stream word valid |
| img_data | input | 32 | Image stream word |
| img_ready | output | 1 | Image word consumed |
| phase | output | 3 | Current phase code (see R13) |
| done | output | 1 | Run finished without failure |
| error | output | 1 | Run finished with a failure |
| fail_phase | output | 3 | Phase code of the first failure, 0 if none |

## Verification
A wrong step state shows up at once on the configuration channel. The offset or the written word differs from the order in R4 and R9 at the next acknowledged access, or a flush has the wrong length on the data channel. A wrong timeout or poll counter appears only at the end of a run, either as a done that should be an error or as an elapsed time shorter than the timeout. So each scenario compares the full write log, the data-channel word stream, the final result and the set of phases visited.

// File: rtl/cfgload_seq.sv
module cfgload_seq #(
  parameter int TIMEOUT_CYC = 50_000_000,
  parameter int POLL_CYC    = 64,
  parameter int FLUSH_N     = 244,
  parameter int LEN_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] img_dwords,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [7:0]       cfg_addr,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_ack,
  input  logic [31:0]      cfg_rdata,
  output logic             mem_valid,
  output logic [31:0]      mem_data,
  input  logic             mem_ready,
  input  logic             img_valid,
  input  logic [31:0]      img_data,
  output logic             img_ready,
  output logic [2:0]       phase,
  output logic             done,
  output logic             error,
  output logic [2:0]       fail_phase
);

  localparam int GMAX = (FLUSH_N > POLL_CYC) ? FLUSH_N : POLL_CYC;
  localparam int GW   = $clog2(GMAX + 1);
  localparam int TW   = $clog2(TIMEOUT_CYC + 1);
  localparam logic [7:0] A_STAT = 8'h1C;
  localparam logic [7:0] A_MODE = 8'h20;
  localparam logic [7:0] A_PROG = 8'h2C;
  localparam logic [7:0] A_IERR = 8'h34;
  localparam logic [31:0] NCLK_MASK = 32'h0000_FF00;

  typedef enum logic [4:0] {
    S_IDLE, S_CHK_EN, S_CHK_MODE,
    U_HIP, U_MODE, U_NCLK1, U_FLUSH1, U_CFG, U_RDY, U_NCLK2, U_FLUSH2, U_XFER,
    U_AB_MODE, U_AB_HIP,
    P_NCLK, P_DATA, P_ERR,
    T_XFER, T_CFG, T_NCLK, T_FLUSH, T_RDY, T_LATCH, T_LCLR, T_MODE, T_HIP,
    T_PLD, T_USER,
    S_DONE, S_FAIL
  } step_t;

  typedef enum logic [2:0] {O_NONE, O_RMW, O_READ, O_POLL, O_FLUSH, O_DATA} op_t;
  typedef enum logic [1:0] {X_RD, X_WR, X_GAP, X_MEM} sub_t;

  step_t            step, nxt;
  sub_t             sub;
  op_t              op;
  logic [7:0]       d_addr;
  logic [31:0]      d_clr, d_set;
  logic [4:0]       d_bit;
  logic             d_exp;
  logic [GW-1:0]    gcnt;
  logic [TW-1:0]    tmo;
  logic [LEN_W-1:0] left;
  logic [31:0]      wbuf;
  logic             recov, bad, lat;
  logic [2:0]       fail_r;
  logic             rbit, hit, ok, tmo_hit, rd_done, fin;
  logic             end_td, td_fail, fail_now;

  function automatic logic is_mem(step_t s);
    return s inside {U_FLUSH1, U_FLUSH2, T_FLUSH, P_DATA};
  endfunction

  always_comb begin
    op = O_NONE; d_addr = A_STAT; d_clr = '0; d_set = '0; d_bit = 5'd0; d_exp = 1'b0;
    case (step)
      S_CHK_EN:   begin op = O_READ; d_bit = 5'd20; end
      S_CHK_MODE: begin op = O_READ; d_addr = A_MODE; d_bit = 5'd0; end
      U_HIP:      begin op = O_RMW; d_addr = A_MODE; d_set = 32'h2; end
      U_MODE:     begin op = O_RMW; d_addr = A_MODE; d_set = 32'h1; end
      U_NCLK1, U_NCLK2, T_NCLK:
                  begin op = O_RMW; d_addr = A_MODE; d_clr = NCLK_MASK; d_set = 32'h0100; end
      P_NCLK:     begin op = O_RMW; d_addr = A_MODE; d_clr = NCLK_MASK; d_set = 32'h0800; end
      U_FLUSH1, U_FLUSH2, T_FLUSH: op = O_FLUSH;
      U_CFG:      begin op = O_RMW; d_addr = A_PROG; d_set = 32'h1; end
      U_RDY:      begin op = O_POLL; d_bit = 5'd18; d_exp = 1'b1; end
      U_XFER:     begin op = O_RMW; d_addr = A_PROG; d_set = 32'h2; end
      U_AB_MODE, T_MODE: begin op = O_RMW; d_addr = A_MODE; d_clr = 32'h1; end
      U_AB_HIP, T_HIP:   begin op = O_RMW; d_addr = A_MODE; d_clr = 32'h2; end
      P_DATA:     op = O_DATA;
      P_ERR:      begin op = O_READ; d_bit = 5'd19; end
      T_XFER:     begin op = O_RMW; d_addr = A_PROG; d_clr = 32'h2; end
      T_CFG:      begin op = O_RMW; d_addr = A_PROG; d_clr = 32'h1; end
      T_RDY:      begin op = O_POLL; d_bit = 5'd18; d_exp = 1'b0; end
      T_LATCH:    begin op = O_READ; d_addr = A_IERR; d_bit = 5'd5; end
      T_LCLR:     begin op = O_RMW; d_addr = A_IERR; d_set = 32'h20; end
      T_PLD:      begin op = O_POLL; d_bit = 5'd24; d_exp = 1'b1; end
      T_USER:     begin op = O_POLL; d_bit = 5'd21; d_exp = 1'b1; end
      default: ;
    endcase
  end

  assign rbit    = cfg_rdata[d_bit];
  assign hit     = rbit == d_exp;
  assign ok      = (op != O_POLL) || hit;
  assign tmo_hit = tmo >= TW'(TIMEOUT_CYC);
  assign rd_done = (sub == X_RD) && cfg_ack;

  always_comb begin
    case (op)
      O_RMW:   fin = (sub == X_WR) && cfg_ack;
      O_READ:  fin = rd_done;
      O_POLL:  fin = rd_done && (hit || tmo_hit);
      O_FLUSH: fin = (sub == X_MEM) && mem_ready && (gcnt == GW'(FLUSH_N - 1));
      O_DATA:  fin = (sub == X_MEM) && img_valid && mem_ready && (left == LEN_W'(1));
      default: fin = 1'b0;
    endcase
  end

  always_comb begin
    nxt = step; end_td = 1'b0; td_fail = 1'b0; fail_now = 1'b0;
    case (step)
      S_CHK_EN:   begin nxt = rbit ? S_CHK_MODE : S_FAIL; fail_now = !rbit; end
      S_CHK_MODE: nxt = rbit ? T_XFER : U_HIP;
      U_HIP:      nxt = U_MODE;
      U_MODE:     nxt = U_NCLK1;
      U_NCLK1:    nxt = U_FLUSH1;
      U_FLUSH1:   nxt = U_CFG;
      U_CFG:      nxt = U_RDY;
      U_RDY:      begin nxt = ok ? U_NCLK2 : U_AB_MODE; fail_now = !ok; end
      U_NCLK2:    nxt = U_FLUSH2;
      U_FLUSH2:   nxt = U_XFER;
      U_XFER:     nxt = P_NCLK;
      U_AB_MODE:  nxt = U_AB_HIP;
      U_AB_HIP:   nxt = S_FAIL;
      P_NCLK:     nxt = (left == '0) ? P_ERR : P_DATA;
      P_DATA:     nxt = P_ERR;
      P_ERR:      begin nxt = T_XFER; fail_now = rbit; end
      T_XFER:     nxt = T_CFG;
      T_CFG:      nxt = T_NCLK;
      T_NCLK:     nxt = T_FLUSH;
      T_FLUSH:    nxt = T_RDY;
      T_RDY:      if (ok) nxt = T_LATCH; else begin end_td = 1'b1; td_fail = 1'b1; end
      T_LATCH:    nxt = rbit ? T_LCLR : T_MODE;
      T_LCLR:     nxt = T_MODE;
      T_MODE:     nxt = T_HIP;
      T_HIP:      if (lat) end_td = 1'b1; else nxt = T_PLD;
      T_PLD:      if (ok) nxt = T_USER; else begin end_td = 1'b1; td_fail = 1'b1; end
      T_USER:     begin end_td = 1'b1; td_fail = !ok; end
      default: ;
    endcase
    if (end_td) begin
      if (recov) nxt = U_HIP;
      else if (bad || td_fail) begin nxt = S_FAIL; fail_now = td_fail; end
      else nxt = S_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= S_IDLE; sub <= X_RD; gcnt <= '0; tmo <= '0; left <= '0;
      wbuf <= '0; recov <= 1'b0; bad <= 1'b0; lat <= 1'b0; fail_r <= 3'd0;
    end else if (step == S_IDLE || step == S_DONE || step == S_FAIL) begin
      if (start) begin
        step <= S_CHK_EN; sub <= X_RD; left <= img_dwords; gcnt <= '0; tmo <= '0;
        recov <= 1'b0; bad <= 1'b0; lat <= 1'b0; fail_r <= 3'd0;
      end
    end else if (fin) begin
      step <= nxt;
      sub  <= is_mem(nxt) ? X_MEM : X_RD;
      gcnt <= '0;
      tmo  <= '0;
      if (step == S_CHK_MODE) recov <= rbit;
      if (end_td && recov) recov <= 1'b0;
      if (step == T_LATCH) lat <= rbit;
      if (fail_now && !bad) begin bad <= 1'b1; fail_r <= phase; end
    end else begin
      if (!tmo_hit) tmo <= tmo + TW'(1);
      case (sub)
        X_RD: if (cfg_ack) begin
          if (op == O_RMW) begin
            wbuf <= (cfg_rdata & ~d_clr) | d_set;
            sub  <= X_WR;
          end else if (op == O_POLL) begin
            sub  <= X_GAP;
            gcnt <= '0;
          end
        end
        X_GAP: if (gcnt == GW'(POLL_CYC - 1)) begin
          sub <= X_RD; gcnt <= '0;
        end else gcnt <= gcnt + GW'(1);
        X_MEM: begin
          if (op == O_FLUSH && mem_ready) gcnt <= gcnt + GW'(1);
          if (op == O_DATA && img_valid && mem_ready) left <= left - LEN_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (step)
      S_IDLE: phase = 3'd0;
      S_CHK_EN, S_CHK_MODE: phase = 3'd1;
      U_HIP, U_MODE, U_NCLK1, U_FLUSH1, U_CFG, U_RDY, U_NCLK2, U_FLUSH2, U_XFER,
      U_AB_MODE, U_AB_HIP: phase = 3'd3;
      P_NCLK, P_DATA, P_ERR: phase = 3'd4;
      S_DONE: phase = 3'd6;
      S_FAIL: phase = 3'd7;
      default: phase = recov ? 3'd2 : 3'd5;
    endcase
  end

  assign cfg_req    = (op == O_RMW || op == O_READ || op == O_POLL) && (sub == X_RD || sub == X_WR);
  assign cfg_we     = (op == O_RMW) && (sub == X_WR);
  assign cfg_addr   = d_addr;
  assign cfg_wdata  = wbuf;
  assign mem_valid  = (sub == X_MEM) && ((op == O_FLUSH) || (op == O_DATA && img_valid));
  assign mem_data   = (op == O_DATA) ? img_data : 32'hFFFF_FFFF;
  assign img_ready  = (sub == X_MEM) && (op == O_DATA) && mem_ready;
  assign done       = step == S_DONE;
  assign error      = step == S_FAIL;
  assign fail_phase = fail_r;

endmodule

module cfgload_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_req,
  input logic        cfg_we,
  input logic        cfg_ack,
  input logic [7:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_data,
  input logic [2:0]  phase,
  input logic        done,
  input logic        error
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd0 |-> !cfg_req && !mem_valid);

  a_r2_check_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd1 |-> !cfg_we && !mem_valid);

  a_r5_flush_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && phase != 3'd4 |-> mem_data == 32'hFFFF_FFFF);

  a_r7_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_data));

  a_r12_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_we) && $stable(cfg_addr) && $stable(cfg_wdata));

  a_r12_write_targets: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_we |-> cfg_addr == 8'h20 || cfg_addr == 8'h2C || cfg_addr == 8'h34);

  a_r13_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && mem_valid));

  a_r13_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

endmodule

bind cfgload_seq cfgload_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_ack(cfg_ack),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_data(mem_data), .phase(phase), .done(done), .error(error)
);

// File: tb/sim_cfgload_seq.sv
`timescale 1ns/1ps
module sim_cfgload_seq;
  localparam int TMO = 300;
  localparam int LW  = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start;
  logic [LW-1:0] img_dwords;
  logic cfg_req, cfg_we, cfg_ack;
  logic [7:0] cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic mem_valid, mem_ready, img_valid, img_ready;
  logic [31:0] mem_data, img_data;
  logic [2:0] phase, fail_phase;
  logic done, error;

  cfgload_seq #(.TIMEOUT_CYC(TMO), .POLL_CYC(5), .FLUSH_N(244), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .img_dwords(img_dwords),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata), .mem_valid(mem_valid), .mem_data(mem_data),
    .mem_ready(mem_ready), .img_valid(img_valid), .img_data(img_data), .img_ready(img_ready),
    .phase(phase), .done(done), .error(error), .fail_phase(fail_phase));

  // fields: en pre rdy cerr latch user | len | done err fp | data writes | cfg writes
  localparam logic [38:0] TBL [8] = '{
    {6'b101001, 8'd5, 1'b1, 1'b0, 3'd0, 12'd737, 8'd12},
    {6'b001001, 8'd5, 1'b0, 1'b1, 3'd1, 12'd0,   8'd0},
    {6'b111001, 8'd3, 1'b1, 1'b0, 3'd0, 12'd979, 8'd17},
    {6'b100001, 8'd4, 1'b0, 1'b1, 3'd3, 12'd244, 8'd6},
    {6'b101101, 8'd2, 1'b0, 1'b1, 3'd4, 12'd734, 8'd12},
    {6'b101010, 8'd1, 1'b1, 1'b0, 3'd0, 12'd733, 8'd13},
    {6'b101000, 8'd1, 1'b0, 1'b1, 3'd5, 12'd733, 8'd12},
    {6'b101001, 8'd0, 1'b1, 1'b0, 3'd0, 12'd732, 8'd12}
  };

  localparam logic [39:0] SEQ0 [12] = '{
    {8'h20, 32'h5512}, {8'h20, 32'h5513}, {8'h20, 32'h0113}, {8'h2C, 32'h1},
    {8'h20, 32'h0113}, {8'h2C, 32'h3},    {8'h20, 32'h0813}, {8'h2C, 32'h1},
    {8'h2C, 32'h0},    {8'h20, 32'h0113}, {8'h20, 32'h0112}, {8'h20, 32'h0110}
  };

  int nchk = 0, nerr = 0;
  bit finished = 0;

  logic k_en, k_rdy, k_cerr, k_user, ld;
  logic [31:0] i_mode, i_prog, i_ierr;
  logic [31:0] m_mode, m_prog, m_ierr, m_stat;
  logic [39:0] wlog [64];
  int nwr, nmem, merr, img_idx, cyc, cur_len;
  bit cur_pre;
  logic [7:0] seen;

  always_comb begin
    m_stat = 32'h0;
    m_stat[18] = k_rdy && m_prog[0];
    m_stat[19] = k_cerr;
    m_stat[20] = k_en;
    m_stat[21] = k_user && !m_mode[0];
    m_stat[24] = k_user && !m_mode[0];
  end

  function automatic logic [31:0] exp_mem(int idx);
    int b = cur_pre ? 244 : 0;
    if (idx < b + 488) return 32'hFFFF_FFFF;
    if (idx < b + 488 + cur_len) return 32'hA000_0000 + 32'(idx - b - 488);
    return 32'hFFFF_FFFF;
  endfunction

  assign img_valid = 1'b1;
  assign img_data  = 32'hA000_0000 + 32'(img_idx);
  assign mem_ready = (cyc % 3) != 2;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (start) seen <= 8'h0; else seen[phase] <= 1'b1;
    if (ld) begin
      m_mode <= i_mode; m_prog <= i_prog; m_ierr <= i_ierr;
      nwr <= 0; nmem <= 0; merr <= 0; img_idx <= 0; cfg_ack <= 1'b0;
    end else begin
      if (cfg_req && !cfg_ack) begin
        cfg_ack <= 1'b1;
        case (cfg_addr)
          8'h1C: cfg_rdata <= m_stat;
          8'h20: cfg_rdata <= m_mode;
          8'h2C: cfg_rdata <= m_prog;
          8'h34: cfg_rdata <= m_ierr;
          default: cfg_rdata <= 32'h0;
        endcase
        if (cfg_we) begin
          case (cfg_addr)
            8'h20: m_mode <= cfg_wdata;
            8'h2C: m_prog <= cfg_wdata;
            8'h34: m_ierr <= m_ierr & ~cfg_wdata;
            default: ;
          endcase
          if (nwr < 64) wlog[nwr] <= {cfg_addr, cfg_wdata};
          nwr <= nwr + 1;
        end
      end else cfg_ack <= 1'b0;
      if (mem_valid && mem_ready) begin
        if (mem_data !== exp_mem(nmem)) merr <= merr + 1;
        nmem <= nmem + 1;
      end
      if (img_valid && img_ready) img_idx <= img_idx + 1;
    end
  end

  task automatic chk(input bit good, input string what, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!good) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", what, act, expv);
    end
  endtask

  task automatic run(input int i);
    logic [38:0] e = TBL[i];
    int t0, el, guard;
    int bad_seq;
    @(negedge clk);
    k_en = e[38]; cur_pre = e[37]; k_rdy = e[36]; k_cerr = e[35]; k_user = e[33];
    cur_len = int'(e[32:25]);
    i_mode = e[37] ? 32'h5513 : 32'h5510;
    i_prog = e[37] ? 32'h3 : 32'h0;
    i_ierr = e[34] ? 32'h20 : 32'h0;
    ld = 1'b1;
    @(negedge clk);
    ld = 1'b0; img_dwords = LW'(cur_len); start = 1'b1; t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!(done || error) && guard < 20000) begin @(negedge clk); guard++; end
    el = cyc - t0;
    chk(done == e[24] && error == e[23], $sformatf("R13 scen %0d done/error", i), {done, error}, e[24:23]);
    chk(fail_phase == e[22:20], $sformatf("R13 scen %0d fail phase", i), fail_phase, e[22:20]);
    chk(nmem == int'(e[19:8]), $sformatf("R5 scen %0d data write count", i), nmem, e[19:8]);
    chk(merr == 0, $sformatf("R7 scen %0d data word mismatches", i), merr, 0);
    chk(nwr == int'(e[7:0]), $sformatf("R4 scen %0d config write count", i), nwr, e[7:0]);
    case (i)
      0: begin
        bad_seq = 0;
        for (int k = 0; k < 12; k++) if (wlog[k] !== SEQ0[k]) bad_seq++;
        chk(bad_seq == 0, "R4 R9 R12 write order and values", bad_seq, 0);
        chk((seen & 8'h3F) == 8'h3A, "R13 phases visited", seen, 8'h3A);
      end
      1: chk(nmem == 0 && nwr == 0, "R2 nothing written when disabled", {nmem[15:0], nwr[15:0]}, 0);
      2: begin
        chk(wlog[0] === {8'h2C, 32'h1}, "R3 recovery starts with transfer clear", wlog[0], {8'h2C, 32'h1});
        chk(wlog[4] === {8'h20, 32'h0110}, "R3 recovery ends with clock select clear", wlog[4], {8'h20, 32'h0110});
        chk((seen & 8'h3F) == 8'h3E, "R3 recover phase shown", seen, 8'h3E);
      end
      3: begin
        chk(wlog[5] === {8'h20, 32'h0110}, "R6 abort clears mode then clock select", wlog[5], {8'h20, 32'h0110});
        chk(el > TMO, "R6 arm wait lasted the timeout", el, TMO);
      end
      4: chk(wlog[11] === {8'h20, 32'h0110}, "R8 return sequence ran after stream error", wlog[11], {8'h20, 32'h0110});
      5: chk(wlog[10] === {8'h34, 32'h20}, "R10 latch written back as one", wlog[10], {8'h34, 32'h20});
      6: chk(el > TMO, "R11 return wait lasted the timeout", el, TMO);
      7: chk(wlog[6] === {8'h20, 32'h0813}, "R7 zero-length stream still sets clock count 0x08", wlog[6], {8'h20, 32'h0813});
      default: ;
    endcase
    repeat (4) @(negedge clk);
    chk(done == e[24] && error == e[23], $sformatf("R13 scen %0d result holds", i), {done, error}, e[24:23]);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; ld = 1'b0; img_dwords = '0; cyc = 0;
    k_en = 0; k_rdy = 0; k_cerr = 0; k_user = 0; cur_pre = 0; cur_len = 0;
    i_mode = 0; i_prog = 0; i_ierr = 0; cfg_rdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    ld = 1'b1;
    @(negedge clk);
    ld = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    chk(phase == 3'd0, "R1 reset phase", phase, 0);
    chk(!done && !error, "R1 reset done/error", {done, error}, 0);
    chk(!cfg_req && !mem_valid, "R1 no requests after reset", {cfg_req, mem_valid}, 0);
    chk(fail_phase == 3'd0, "R1 reset fail phase", fail_phase, 0);
    for (int i = 0; i < 8; i++) run(i);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule